// File: doc/BRIEF.md
# Line-Activity Wake-Up Signaller

While the transceiver is powered down and has no running clock, this block tells the host that the line has come alive. It drives the host-side upstream data line low through an open-drain pull-down. The block is armed only when two conditions hold: the power-down state is active and the asynchronous-awake option is enabled. While armed, any pulse from the analog level detector sets a wake flag through an asynchronous set. The pull-down then turns on at once, without waiting for a clock edge.

The pull-down stays on for a fixed hold time of `HOLD_US` microseconds, which is `H = CLK_KHZ*HOLD_US/1000` clock cycles. A two-flop synchroniser passes the wake flag into the clock domain. The hold timer then counts only on clock edges where the oscillator reports that it is stable. A slow oscillator start-up, or a dropout during the hold, therefore stretches the time the line is held low. When power-down is left or the enable is cleared, the pull-down is released at once and the timer is cleared.

Top module: `line_wake_signaller`

## Requirements
- R1: While reset is asserted, and after it is released with no line activity, `wake_pull_n` is 1. A level-detect pulse that arrives while reset is asserted does not assert the pull-down.
- R2: The block is armed only when `pwr_down`=1 and `awake_en`=1. If either input is 0, a level-detect pulse leaves `wake_pull_n` at 1, both at once and on every later cycle.
- R3: A rising `lvl_detect` while armed drives `wake_pull_n` to 0 combinationally, with no clock edge between the pulse and the output change.
- R4: `legacy_lvl_en` has no effect. The hold timing is the same whether it is 0 or 1.
- R5: With `osc_ready` held at 1, count as edge 1 the first rising clock edge after the activity. `wake_pull_n` stays 0 through edge H+1 and returns to 1 on edge H+2. This is two synchroniser edges followed by H counting edges. With the defaults, H = 64*2000/1000 = 128.
- R6: The timer advances only on edges where `osc_ready`=1. If `osc_ready` is 0 at the time of activity and rises so that it is first seen at edge m+1 (m ≥ 2), the release moves to edge m+H. Each edge with `osc_ready`=0 during the count delays the release by one edge.
- R7: Further `lvl_detect` pulses while the pull-down is already on do not restart the hold. The release edge stays the one set by the first pulse.
- R8: Clearing `pwr_down` or `awake_en` during a hold sets `wake_pull_n` to 1 at once and clears the timer. When the block is armed again, the pull-down stays off, and the next activity gets a full hold of H+2 edges.
- R9: The hold counter never exceeds H-1. Between two edges it only increments by one or returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; the hold timer runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_down | input | 1 | 1 while the transceiver is in its deactivated state |
| awake_en | input | 1 | Asynchronous-awake enable configuration bit |
| legacy_lvl_en | input | 1 | Legacy level-detect configuration bit; it is ignored |
| lvl_detect | input | 1 | Raw asynchronous activity pulse from the line level detector |
| osc_ready | input | 1 | 1 when the oscillator is stable; qualifies each hold count edge |
| wake_pull_n | output | 1 | Active-low pull-down enable for the upstream bus line |

## Verification
The bench pulses the level detector between clock edges and reads the output before the next edge. A design that waits for the clock to assert the pull-down fails this check. It measures the release edge exactly with the oscillator steady, with the oscillator starting late, and with the oscillator dropping out partway through the hold. A timer that counts raw clock edges, or that forgets the synchroniser latency, releases the line on the wrong edge. A second pulse is sent in the middle of a hold to catch a timer that restarts. The bench also disarms the block partway through a hold and re-arms it. A design that keeps the flag or the count would pull the line low again, or would release the next hold early.

// File: rtl/lws_pkg.sv
package lws_pkg;

  // Number of clock cycles in a hold window of 'us' microseconds at 'khz' kHz.
  function automatic int hold_cycles(input int khz, input int us);
    return (khz * us) / 1000;
  endfunction

  // Width of a counter that must reach n-1.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lws_rst_sync.sv
module lws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/lws_wake_flag.sv
module lws_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,   // asynchronous set from line activity
  input  logic clr,     // synchronous clear
  output logic flag_q
);
  logic flag_d;

  always_comb flag_d = clr ? 1'b0 : flag_q;

  always_ff @(posedge clk or negedge rst_n or posedge set_a) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_a) flag_q <= 1'b1;
    else            flag_q <= flag_d;
  end
endmodule

// File: rtl/lws_sync.sv
module lws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_a,
  output logic q_s
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q_s = sr_q[STAGES-1];
endmodule

// File: rtl/lws_hold_timer.sv
module lws_hold_timer #(
  parameter int HOLD_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic flag_s,     // synchronised wake flag
  input  logic flag_q,     // live wake flag
  input  logic osc_ready,
  output logic expire
);
  import lws_pkg::*;
  localparam int CW = cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          run;
  logic          at_last;
  logic          cnt_en;

  assign run     = armed & flag_s & flag_q;
  assign at_last = (cnt_q == LAST);
  assign cnt_en  = run & osc_ready;
  assign expire  = cnt_en & at_last;

  always_comb begin
    if (!run)         cnt_d = '0;
    else if (!cnt_en) cnt_d = cnt_q;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: the counter stays inside its window
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: the counter moves only by one step up or back to zero
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CW'(1)) || (cnt_q == '0)));

  // R6: no progress while the oscillator is not ready
  assert_hold_on_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_ready && armed && run) |=> $stable(cnt_q));
endmodule

// File: rtl/line_wake_signaller.sv
module line_wake_signaller #(
  parameter int CLK_KHZ = 64,
  parameter int HOLD_US = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic awake_en,
  input  logic legacy_lvl_en,
  input  logic lvl_detect,
  input  logic osc_ready,
  output logic wake_pull_n
);
  import lws_pkg::*;
  localparam int HOLD_CYCLES = hold_cycles(CLK_KHZ, HOLD_US);

  logic rst_s_n;
  logic armed;
  logic set_a;
  logic flag_q;
  logic flag_s;
  logic expire;
  logic flag_clr;

  assign armed    = pwr_down & awake_en;
  assign set_a    = lvl_detect & armed;
  assign flag_clr = expire | ~armed;

  lws_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_s_n)
  );

  lws_wake_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .set_a  (set_a),
    .clr    (flag_clr),
    .flag_q (flag_q)
  );

  lws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_a   (flag_q),
    .q_s   (flag_s)
  );

  lws_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .armed     (armed),
    .flag_s    (flag_s),
    .flag_q    (flag_q),
    .osc_ready (osc_ready),
    .expire    (expire)
  );

  assign wake_pull_n = ~(flag_q & armed);

  // R8: a disarmed edge leaves the flag cleared
  assert_flag_cleared_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !armed |=> (!flag_q || armed));

  // R5: the line is released only by timer expiry or by disarming
  assert_release_cause_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(wake_pull_n) |-> ($past(expire) || !$past(armed) || !armed));

  // R4: toggling the legacy bit while idle leaves the output where it was
  assert_legacy_ignored_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!$stable(legacy_lvl_en) && $stable(armed) && !lvl_detect && !$past(lvl_detect)
     && !$past(expire)) |-> (wake_pull_n == $past(wake_pull_n)));
endmodule

// File: tb/line_wake_signaller_bench.sv
module line_wake_signaller_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ = 64;
  localparam int US  = 2000;
  localparam int H   = KHZ * US / 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_down, awake_en, legacy_lvl_en, lvl_detect, osc_ready;
  logic wake_pull_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    cyc;
    bit    exp;
    string req;
  } item_t;
  item_t q[$];

  line_wake_signaller #(.CLK_KHZ(KHZ), .HOLD_US(US)) u_line_wake_signaller (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_down      (pwr_down),
    .awake_en      (awake_en),
    .legacy_lvl_en (legacy_lvl_en),
    .lvl_detect    (lvl_detect),
    .osc_ready     (osc_ready),
    .wake_pull_n   (wake_pull_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wake_pull_n=%0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_at(input int c, input bit e, input string req);
    item_t it;
    it.cyc = c; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compare queued expectations at the falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (q.size() != 0 && q[0].cyc <= cyc) begin
        it = q.pop_front();
        check(it.req, wake_pull_n, it.exp);
      end
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
    #2;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic pulse(input bit exp_low, input string req, output int c0);
    @(negedge clk);
    #2;
    c0 = cyc;
    lvl_detect = 1'b1;
    #1 check(req, wake_pull_n, !exp_low);
    #1 lvl_detect = 1'b0;
  endtask

  task automatic full_hold(input string req);
    int c0;
    pulse(1'b1, "R3", c0);
    expect_at(c0 + 1, 1'b0, req);
    expect_at(c0 + H + 1, 1'b0, req);
    expect_at(c0 + H + 2, 1'b1, req);
    drain();
    wait_cyc(cyc + 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: wake_pull_n=%0b expected run to end", wake_pull_n);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; pwr_down = 1'b1; awake_en = 1'b1; legacy_lvl_en = 1'b0;
    lvl_detect = 1'b0; osc_ready = 1'b1;
    // R1: reset holds the flag even with activity
    repeat (2) @(negedge clk);
    #2 lvl_detect = 1'b1;
    #1 check("R1", wake_pull_n, 1'b1);
    #1 lvl_detect = 1'b0;
    @(negedge clk); check("R1", wake_pull_n, 1'b1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", wake_pull_n, 1'b1);

    // R5: steady oscillator, exact release edge
    full_hold("R5");

    // R4: legacy bit set, identical timing
    legacy_lvl_en = 1'b1;
    wait_cyc(cyc + 2);
    full_hold("R4");
    legacy_lvl_en = 1'b0;
    wait_cyc(cyc + 2);

    // R7: second pulse mid-hold does not restart
    pulse(1'b1, "R3", c0);
    wait_cyc(c0 + 50);
    lvl_detect = 1'b1;
    #1 check("R7", wake_pull_n, 1'b0);
    #1 lvl_detect = 1'b0;
    expect_at(c0 + H + 1, 1'b0, "R7");
    expect_at(c0 + H + 2, 1'b1, "R7");
    drain();
    wait_cyc(cyc + 4);

    // R6: oscillator still starting up at activity time
    osc_ready = 1'b0;
    pulse(1'b1, "R3", c0);
    expect_at(c0 + 10, 1'b0, "R6");
    wait_cyc(c0 + 20);
    osc_ready = 1'b1;
    expect_at(c0 + 19 + H, 1'b0, "R6");
    expect_at(c0 + 20 + H, 1'b1, "R6");
    drain();
    wait_cyc(cyc + 4);

    // R6: oscillator drops out for ten edges during the hold
    pulse(1'b1, "R3", c0);
    wait_cyc(c0 + 29);
    osc_ready = 1'b0;
    wait_cyc(c0 + 39);
    osc_ready = 1'b1;
    expect_at(c0 + H + 2, 1'b0, "R6");
    expect_at(c0 + H + 11, 1'b0, "R6");
    expect_at(c0 + H + 12, 1'b1, "R6");
    drain();
    wait_cyc(cyc + 4);

    // R2: not in power-down
    pwr_down = 1'b0;
    pulse(1'b0, "R2", c0);
    expect_at(c0 + 3, 1'b1, "R2");
    expect_at(c0 + 20, 1'b1, "R2");
    drain();
    pwr_down = 1'b1;
    // R2: enable bit clear
    awake_en = 1'b0;
    pulse(1'b0, "R2", c0);
    expect_at(c0 + 3, 1'b1, "R2");
    drain();
    awake_en = 1'b1;
    expect_at(cyc + 5, 1'b1, "R2");
    drain();
    wait_cyc(cyc + 4);

    // R8: leave power-down mid-hold
    pulse(1'b1, "R3", c0);
    wait_cyc(c0 + 40);
    pwr_down = 1'b0;
    #1 check("R8", wake_pull_n, 1'b1);
    wait_cyc(c0 + 45);
    pwr_down = 1'b1;
    expect_at(c0 + 46, 1'b1, "R8");
    expect_at(c0 + 60, 1'b1, "R8");
    drain();
    full_hold("R8");

    // R8: clear enable mid-hold
    pulse(1'b1, "R3", c0);
    wait_cyc(c0 + 70);
    awake_en = 1'b0;
    #1 check("R8", wake_pull_n, 1'b1);
    wait_cyc(c0 + 75);
    awake_en = 1'b1;
    expect_at(c0 + 80, 1'b1, "R8");
    drain();
    full_hold("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule